// File: doc/BRIEF.md
# CPU Reset and Interrupt Entry Sequencer

This block runs the entry phase of an 8-bit processor. It handles the release of reset and the three interrupt kinds: the software break, the maskable level request and the non-maskable edge request. Every clock is one bus cycle. The block drives the 16-bit address, the read/write strobe and the write data. It also owns the program counter, the 8-bit stack pointer and the interrupt-mask flag. The instruction decoder and the execution units sit outside and take over once the first opcode of the handler or program is on the bus.

All four entries use the same seven-cycle skeleton: two throw-away reads at the current PC, three stack cycles, then a low and a high vector read. The eighth cycle is the opcode fetch, and `done` pulses on it. A reset entry still runs the three stack cycles with real addresses and still moves the stack pointer, but it holds the strobe at read. The cycle count therefore matches an interrupt entry exactly, and no stack byte is overwritten. After the opcode fetch the sequencer waits in a run state. It keeps the address on PC and accepts new requests there.

Top module: `cpu_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge the sequencer stays idle. `rw` is 1 (1 = read, 0 = write), `done` is 0, and `sp` and `iflag` keep their values.
- R2: In bus cycles 1 and 2 of any entry, `addr` equals the PC held at the start of the entry and `rw` is 1. Cycle k is the cycle after the k-th rising edge that accepts the entry; for reset this is the k-th edge with `rst_n` high.
- R3: In cycles 3, 4 and 5, `addr` is 0x0100 plus the stack pointer as it stands before that cycle's decrement. `sp` falls by exactly one per stack cycle, wrapping modulo 256.
- R4: A reset entry never drives `rw` to 0. Its stack cycles are reads.
- R5: Cycle 6 reads the vector low byte and cycle 7 reads the high byte at vector+1, and both bytes load into PC. The vector is 0xFFFC for reset, 0xFFFA for NMI, and 0xFFFE for IRQ and break.
- R6: `done` is 1 in cycle 8 only, for a single cycle. In that cycle `addr` equals the loaded PC, `sp` is three below its starting value and `iflag` is 1.
- R7: In the stack cycles of a break, IRQ or NMI entry, `rw` is 0 and `data_out` carries PC high, then PC low, then status. Status has bit 5 = 1, bit 4 = 1 only for break, bit 2 = the mask flag before entry, and all other bits 0.
- R8: A low `irq_n` starts an entry only while `iflag` is 0. A `clr_i` pulse in the run state clears `iflag` on the next edge.
- R9: NMI is taken on a falling edge of `nmi_n`. When requests coincide, NMI wins over break and break wins over IRQ. A break request is acted on only in the run state; one raised during an entry is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| irq_n | input | 1 | Active-low level interrupt request, masked by `iflag` |
| nmi_n | input | 1 | Active-low non-maskable request, falling-edge sensitive |
| brk_req | input | 1 | One-cycle break request from the decoder |
| clr_i | input | 1 | One-cycle request from execution to clear the mask flag |
| data_in | input | 8 | Read data bus |
| addr | output | 16 | Address bus |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| data_out | output | 8 | Write data for stack pushes |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| iflag | output | 1 | Interrupt-mask flag |
| done | output | 1 | One-cycle pulse on the first opcode fetch |

## Verification
The hardest situations to reach are colliding requests and a break request that arrives in the middle of an entry. The bench raises NMI and break on the same edge, and break with an unmasked IRQ on the same edge. Inside a break entry it pulses a second break in cycle 4, then watches the cycles after the opcode fetch to confirm no second entry starts. The IRQ path must first have its mask cleared through `clr_i`. The bench therefore holds `irq_n` low across masked and unmasked windows, so it sees both the ignored request and the taken one. Random vectors and random reset hold lengths run through a seeded loop mixed with these directed cases.

// File: rtl/cpu_entry_pkg.sv
package cpu_entry_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [7:0] STACK_PAGE = 8'h01;

    typedef enum logic [3:0] {
        PH_HOLD,
        PH_DUM1,
        PH_DUM2,
        PH_STK1,
        PH_STK2,
        PH_STK3,
        PH_VLO,
        PH_VHI,
        PH_FETCH,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        K_RESET,
        K_NMI,
        K_IRQ,
        K_BRK
    } kind_e;

    function automatic logic is_stack(phase_e p);
        return (p == PH_STK1) || (p == PH_STK2) || (p == PH_STK3);
    endfunction

    function automatic logic [ADDR_W-1:0] vector_for(kind_e k,
                                                     logic [ADDR_W-1:0] rst_v,
                                                     logic [ADDR_W-1:0] nmi_v,
                                                     logic [ADDR_W-1:0] irq_v);
        case (k)
            K_RESET: return rst_v;
            K_NMI:   return nmi_v;
            default: return irq_v;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(kind_e k, logic i);
        return {2'b00, 1'b1, (k == K_BRK), 1'b0, i, 2'b00};
    endfunction

endpackage

// File: rtl/entry_ctrl.sv
module entry_ctrl
    import cpu_entry_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   irq_n,
    input  logic   nmi_n,
    input  logic   brk_req,
    input  logic   iflag,
    output phase_e phase,
    output kind_e  kind
);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_edge;
    logic nmi_hit;

    assign nmi_edge = nmi_q & ~nmi_n;
    assign nmi_hit  = nmi_pend | nmi_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_HOLD;
            kind     <= K_RESET;
            nmi_q    <= nmi_n;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            if (nmi_edge) begin
                nmi_pend <= 1'b1;
            end
            case (phase)
                PH_HOLD: begin
                    phase <= PH_DUM1;
                    kind  <= K_RESET;
                end
                PH_FETCH: phase <= PH_RUN;
                PH_RUN: begin
                    if (nmi_hit) begin
                        phase    <= PH_DUM1;
                        kind     <= K_NMI;
                        nmi_pend <= 1'b0;
                    end else if (brk_req) begin
                        phase <= PH_DUM1;
                        kind  <= K_BRK;
                    end else if (!irq_n && !iflag) begin
                        phase <= PH_DUM1;
                        kind  <= K_IRQ;
                    end
                end
                default: phase <= phase_e'(phase + 4'd1);
            endcase
        end
    end

    // R9: an interrupt entry only starts out of the run state
    a_r9_start_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DUM1 && kind != K_RESET) |-> ($past(phase) == PH_RUN));

    // R6: the opcode fetch is seven cycles after the first dummy read
    a_r6_entry_length: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |-> ($past(phase, 7) == PH_DUM1));

    // R1: a reset entry begins straight from the hold state
    a_r1_reset_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DUM1 && kind == K_RESET) |-> ($past(phase) == PH_HOLD));

endmodule

// File: rtl/entry_regs.sv
module entry_regs
    import cpu_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] pc,
    output logic [7:0]        sp,
    output logic              iflag
);

    // Registers are left untouched while reset is held: only the entry
    // sequence that follows its release changes them.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            case (phase)
                PH_STK1, PH_STK2: sp <= sp - 8'd1;
                PH_STK3: begin
                    sp    <= sp - 8'd1;
                    iflag <= 1'b1;
                end
                PH_VLO: pc[7:0]  <= data_in;
                PH_VHI: pc[15:8] <= data_in;
                PH_RUN: if (clr_i) iflag <= 1'b0;
                default: ;
            endcase
        end
    end

    // R3: each stack cycle lowers the stack pointer by one
    a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        is_stack(phase) |=> (sp == $past(sp) - 8'd1));

    // R5: the high vector byte lands in PC
    a_r5_pc_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_VHI) |=> (pc[15:8] == $past(data_in)));

    // R8: a clear request in the run state drops the mask
    a_r8_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && clr_i) |=> !iflag);

endmodule

// File: rtl/entry_bus.sv
module entry_bus
    import cpu_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RST_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'hFFFA,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 16'hFFFE
) (
    input  phase_e            phase,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [7:0]        sp,
    input  logic              iflag,
    output logic [ADDR_W-1:0] addr,
    output logic              rw,
    output logic [DATA_W-1:0] data_out,
    output logic              done
);

    logic [ADDR_W-1:0] vec;
    logic              push_en;

    assign vec     = vector_for(kind, RST_VEC, NMI_VEC, IRQ_VEC);
    assign push_en = (kind != K_RESET);

    always_comb begin
        addr     = pc;
        rw       = 1'b1;
        data_out = '0;
        done     = 1'b0;
        case (phase)
            PH_STK1: begin
                addr     = {STACK_PAGE, sp};
                rw       = ~push_en;
                data_out = pc[15:8];
            end
            PH_STK2: begin
                addr     = {STACK_PAGE, sp};
                rw       = ~push_en;
                data_out = pc[7:0];
            end
            PH_STK3: begin
                addr     = {STACK_PAGE, sp};
                rw       = ~push_en;
                data_out = status_byte(kind, iflag);
            end
            PH_VLO:   addr = vec;
            PH_VHI:   addr = vec + 16'd1;
            PH_FETCH: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_entry_seq.sv
module cpu_entry_seq
    import cpu_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RST_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'hFFFA,
    parameter logic [ADDR_W-1:0] IRQ_VEC = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              brk_req,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr,
    output logic              rw,
    output logic [DATA_W-1:0] data_out,
    output logic [ADDR_W-1:0] pc,
    output logic [7:0]        sp,
    output logic              iflag,
    output logic              done
);

    phase_e phase;
    kind_e  kind;

    entry_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n   (irq_n),
        .nmi_n   (nmi_n),
        .brk_req (brk_req),
        .iflag   (iflag),
        .phase   (phase),
        .kind    (kind)
    );

    entry_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .clr_i   (clr_i),
        .data_in (data_in),
        .pc      (pc),
        .sp      (sp),
        .iflag   (iflag)
    );

    entry_bus #(
        .RST_VEC (RST_VEC),
        .NMI_VEC (NMI_VEC),
        .IRQ_VEC (IRQ_VEC)
    ) u_bus (
        .phase    (phase),
        .kind     (kind),
        .pc       (pc),
        .sp       (sp),
        .iflag    (iflag),
        .addr     (addr),
        .rw       (rw),
        .data_out (data_out),
        .done     (done)
    );

    // R4: reset entries never write
    a_r4_reset_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_RESET) |-> rw);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: every write lands in the stack page
    a_r3_write_page: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |-> (addr[15:8] == STACK_PAGE));

    // R6: the mask is set whenever the opcode fetch is reached
    a_r6_mask_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> iflag);

endmodule

// File: tb/cpu_entry_seq_tb.sv
`timescale 1ns/1ps
module cpu_entry_seq_tb;

    localparam int KR = 0;
    localparam int KN = 1;
    localparam int KI = 2;
    localparam int KB = 3;

    logic        clk = 1'b0;
    logic        rst_n, irq_n, nmi_n, brk_req, clr_i;
    logic [7:0]  data_in;
    logic [15:0] addr, pc;
    logic        rw, iflag, done;
    logic [7:0]  data_out, sp;

    logic [15:0] rv, nv, iv;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    cpu_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
        .brk_req(brk_req), .clr_i(clr_i), .data_in(data_in),
        .addr(addr), .rw(rw), .data_out(data_out), .pc(pc),
        .sp(sp), .iflag(iflag), .done(done)
    );

    always_comb begin
        case (addr)
            16'hFFFA: data_in = nv[7:0];
            16'hFFFB: data_in = nv[15:8];
            16'hFFFC: data_in = rv[7:0];
            16'hFFFD: data_in = rv[15:8];
            16'hFFFE: data_in = iv[7:0];
            16'hFFFF: data_in = iv[15:8];
            default:  data_in = addr[7:0] ^ 8'h5A;
        endcase
    end

    function automatic logic [15:0] exp_vec_addr(int k);
        case (k)
            KR:      return 16'hFFFC;
            KN:      return 16'hFFFA;
            default: return 16'hFFFE;
        endcase
    endfunction

    function automatic logic [15:0] exp_vec_val(int k);
        case (k)
            KR:      return rv;
            KN:      return nv;
            default: return iv;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Follows an entry from cycle 1 to the cycle after the opcode fetch.
    task automatic run_entry(int k, bit poke);
        logic [15:0] pc0 = pc;
        logic [7:0]  sp0 = sp;
        logic        i0  = iflag;
        logic [15:0] va  = exp_vec_addr(k);
        logic [15:0] vv  = exp_vec_val(k);
        logic [7:0]  st  = 8'h20 | ((k == KB) ? 8'h10 : 8'h00) | (i0 ? 8'h04 : 8'h00);
        for (int c = 1; c <= 9; c++) begin
            @(negedge clk);
            if (c == 1) brk_req = 1'b0;
            if (poke && c == 4) brk_req = 1'b1;
            if (c == 5) brk_req = 1'b0;
            if (c <= 2) begin
                chk(addr == pc0, "R2 dummy addr", addr, pc0);
                chk(rw == 1'b1, "R2 dummy rw", rw, 1);
            end else if (c <= 5) begin
                chk(addr == {8'h01, sp0 - 8'(c - 3)}, "R3 stack addr", addr, {8'h01, sp0 - 8'(c - 3)});
                chk(sp == sp0 - 8'(c - 3), "R3 sp value", sp, sp0 - 8'(c - 3));
                if (k == KR) begin
                    chk(rw == 1'b1, "R4 reset stack read", rw, 1);
                end else begin
                    chk(rw == 1'b0, "R7 push rw", rw, 0);
                    chk(data_out == ((c == 3) ? pc0[15:8] : (c == 4) ? pc0[7:0] : st),
                        "R7 push data", data_out,
                        (c == 3) ? pc0[15:8] : (c == 4) ? pc0[7:0] : st);
                end
            end else if (c == 6) begin
                chk(addr == va, "R5 vector low addr", addr, va);
            end else if (c == 7) begin
                chk(addr == va + 16'd1, "R5 vector high addr", addr, va + 16'd1);
            end else if (c == 8) begin
                chk(done == 1'b1, "R6 done on cycle 8", done, 1);
                chk(pc == vv, "R5 pc loaded", pc, vv);
                chk(addr == vv, "R6 fetch addr", addr, vv);
                chk(sp == sp0 - 8'd3, "R6 sp after entry", sp, sp0 - 8'd3);
                chk(iflag == 1'b1, "R6 mask set", iflag, 1);
            end else begin
                chk(done == 1'b0, "R6 done one cycle", done, 0);
                chk(addr == vv && rw, "R6 run addr", addr, vv);
            end
            if (c < 8) chk(done == 1'b0, "R6 no early done", done, 0);
        end
    endtask

    task automatic quiet(int n, string tag);
        logic [15:0] p0 = pc;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(done == 1'b0 && rw == 1'b1 && addr == p0, tag, {done, rw, addr}, {2'b01, p0});
        end
    endtask

    task automatic do_reset(int n);
        logic [7:0] s0;
        logic       i0;
        rst_n = 1'b0;
        @(negedge clk);
        s0 = sp;
        i0 = iflag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(sp == s0 && iflag == i0, "R1 hold keeps sp/mask", {sp, iflag}, {s0, i0});
            chk(rw == 1'b1 && done == 1'b0, "R1 hold idle bus", {rw, done}, 2'b10);
        end
        rst_n = 1'b1;
        run_entry(KR, 1'b0);
    endtask

    task automatic do_irq();
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk(iflag == 1'b0, "R8 clear mask", iflag, 0);
        irq_n = 1'b0;
        run_entry(KI, 1'b0);
        quiet(4, "R8 masked irq ignored");
        irq_n = 1'b1;
    endtask

    task automatic do_nmi();
        nmi_n = 1'b0;
        run_entry(KN, 1'b0);
        quiet(3, "R9 held nmi no retrigger");
        nmi_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; brk_req = 1'b0; clr_i = 1'b0;
        rv = 16'hC123; nv = 16'h8A55; iv = 16'h9E01;
        repeat (3) @(negedge clk);
        chk(rw == 1'b1 && done == 1'b0, "R1 reset state", {rw, done}, 2'b10);

        do_reset(2);

        // R8: masked IRQ ignored
        irq_n = 1'b0;
        quiet(6, "R8 irq ignored while masked");
        irq_n = 1'b1;
        @(negedge clk);

        // R7 break entry, with a stray break in the middle (R9)
        brk_req = 1'b1;
        run_entry(KB, 1'b1);
        quiet(3, "R9 break during entry dropped");

        do_irq();
        do_nmi();

        // R9 priority: NMI over break
        nmi_n = 1'b0; brk_req = 1'b1;
        run_entry(KN, 1'b0);
        nmi_n = 1'b1;
        @(negedge clk);

        // R9 priority: break over unmasked IRQ (status bit 4 distinguishes)
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        brk_req = 1'b1; irq_n = 1'b0;
        run_entry(KB, 1'b0);
        irq_n = 1'b1;
        @(negedge clk);

        // R1/R4 reset while sp near wrap region and mid-run
        do_reset(1);

        for (int it = 0; it < 24; it++) begin
            int k = int'($urandom % 4);
            rv = 16'($urandom); nv = 16'($urandom); iv = 16'($urandom);
            case (k)
                KR: do_reset(1 + int'($urandom % 5));
                KN: do_nmi();
                KI: do_irq();
                default: begin
                    brk_req = 1'b1;
                    run_entry(KB, 1'($urandom % 2));
                    quiet(2, "R9 random break settle");
                end
            endcase
            repeat (int'($urandom % 3)) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule